// File: doc/BRIEF.md
# Watchdog Timer with Shared Divider

This block is a watchdog timer that shares a single 8-bit power-of-two divider with a general-purpose timer. A select bit in a small control register gives the divider to one of the two users. When the watchdog owns it, the divider stretches the watchdog period as a postscaler. When the timer owns it, the divider slows the timer clock into a prescaled increment strobe, and the watchdog then times out straight from its base counter.

The watchdog counts a free-running tick, and only while a configuration enable is high. Software restarts it with a clear strobe. A sleep strobe also restarts it, and the count keeps running afterwards. Two status flags record how the last power-down or timeout came about. A timeout while awake gives a one-cycle internal reset pulse, and the control register returns to its reset value. A timeout while asleep gives a one-cycle wake pulse instead.

All strobes are single-cycle enables in the `clk_i` domain. The block drives only its internal reset request and has no path to any external reset pin.

Top module: `wdt_shared_div`

## Requirements
- R1: After `rst_ni` is released, `pd_o` and `to_o` are 1, every pulse output is 0, and the control register holds all ones. All ones means the watchdog owns the divider with ratio field 7, so the first timeout comes after 2^BASE_W * 128 ticks.
- R2: A write on `ctrl_wr_i` loads `ctrl_d_i`. Bit 3 is the select bit: 1 gives the divider to the watchdog and 0 gives it to the timer. Bits 2:0 are the ratio field n.
- R3: With the watchdog owning the divider and ratio n, a timeout occurs on exactly tick 2^BASE_W * 2^n after a clear.
- R4: With the timer owning the divider and ratio n, `tmr_inc_o` pulses once every 2^(n+1) `tmr_clk_i` strobes. In this mode the watchdog times out every 2^BASE_W ticks.
- R5: With the watchdog owning the divider, each `tmr_clk_i` strobe appears on `tmr_inc_o` one cycle later.
- R6: While `wdt_en_i` is 0, the watchdog count holds and no timeout occurs.
- R7: `clrwdt_i` clears the watchdog base count, and clears the divider as well when the watchdog owns it. It also sets `pd_o` and `to_o` to 1.
- R8: `sleep_i` clears the count in the same way as R7, sets `pd_o` to 0 and `to_o` to 1, and the watchdog keeps counting from zero.
- R9: A timeout while awake gives a one-cycle `wdt_rst_o` pulse. The same timeout clears `to_o` and returns the control register to all ones.
- R10: A timeout while asleep gives a one-cycle `wake_o` pulse and clears `to_o`. It does not pulse `wdt_rst_o` and it leaves the control register unchanged.
- R11: A write that changes the select bit clears the divider, so no partial count carries over to the new owner.
- R12: `wdt_rst_o` and `wake_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wdt_tick_i | input | 1 | Free-running watchdog tick strobe |
| tmr_clk_i | input | 1 | General timer clock strobe |
| wdt_en_i | input | 1 | Configuration enable for the watchdog |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_d_i | input | 4 | Control write data: select bit and ratio field |
| clrwdt_i | input | 1 | Watchdog clear strobe |
| sleep_i | input | 1 | Sleep entry strobe |
| wdt_rst_o | output | 1 | One-cycle internal reset request on an awake timeout |
| wake_o | output | 1 | One-cycle wake pulse on a timeout during sleep |
| tmr_inc_o | output | 1 | Prescaled timer increment strobe |
| pd_o | output | 1 | Power-down status flag |
| to_o | output | 1 | Time-out status flag |

## Verification
The flag assertions assume that the surrounding core raises `clrwdt_i` and `sleep_i` only as single-cycle strobes. When both strobes are high together, sleep takes priority. The enable assertion assumes that `wdt_en_i` changes only between ticks. The stimulus issues every strobe for exactly one cycle and never raises the two strobes together. It changes the enable only on cycles with no tick, and it sweeps all eight ratios for both owners.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int RATIO_W = 3;
  localparam int CTRL_W  = RATIO_W + 1;

  typedef struct packed {
    logic               sel_wdt;
    logic [RATIO_W-1:0] ratio;
  } wdt_ctrl_t;

  localparam wdt_ctrl_t CTRL_RST = '1;
endpackage

// File: rtl/wdt_base_cnt.sv
module wdt_base_cnt #(
  parameter int W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic clr_i,
  output logic ovf_o
);
  logic [W-1:0] cnt_q;

  assign ovf_o = tick_i & en_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (tick_i && en_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_divider.sv
module wdt_divider #(
  parameter int DIV_W = 8,
  localparam int KW   = $clog2(DIV_W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_evt_i,
  input  logic [KW-1:0] k_i,
  input  logic          clr_i,
  output logic          pulse_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   tap;

  // tap[j]: low j bits saturated, so the next event completes a 2^j period
  assign tap[0] = 1'b1;
  for (genvar j = 1; j <= DIV_W; j++) begin : g_tap
    assign tap[j] = &cnt_q[j-1:0];
  end

  assign pulse_o = in_evt_i & tap[k_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (in_evt_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_shared_div.sv
module wdt_shared_div
  import wdt_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter int DIV_W  = 8,
  localparam int KW    = $clog2(DIV_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wdt_tick_i,
  input  logic              tmr_clk_i,
  input  logic              wdt_en_i,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_d_i,
  input  logic              clrwdt_i,
  input  logic              sleep_i,
  output logic              wdt_rst_o,
  output logic              wake_o,
  output logic              tmr_inc_o,
  output logic              pd_o,
  output logic              to_o
);
  wdt_ctrl_t ctrl_q, ctrl_wdata;
  logic asleep_q;
  logic psa, hold, base_ovf, div_pulse, div_in, div_clr, base_clr;
  logic sel_chg, tmo, rst_fire;
  logic [KW-1:0] k_sel;

  assign ctrl_wdata = wdt_ctrl_t'(ctrl_d_i);
  assign psa        = ctrl_q.sel_wdt;
  assign hold       = clrwdt_i | sleep_i;
  assign sel_chg    = ctrl_wr_i & (ctrl_wdata.sel_wdt != ctrl_q.sel_wdt);
  assign k_sel      = psa ? KW'(ctrl_q.ratio) : KW'(ctrl_q.ratio) + KW'(1);
  assign div_in     = psa ? base_ovf : tmr_clk_i;
  assign tmo        = wdt_en_i & ~hold & (psa ? div_pulse : base_ovf);
  assign rst_fire   = tmo & ~asleep_q;
  assign base_clr   = hold | rst_fire;
  assign div_clr    = (psa & hold) | sel_chg | rst_fire;

  wdt_base_cnt #(.W(BASE_W)) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (wdt_tick_i),
    .en_i   (wdt_en_i),
    .clr_i  (base_clr),
    .ovf_o  (base_ovf)
  );

  wdt_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_evt_i (div_in),
    .k_i      (k_sel),
    .clr_i    (div_clr),
    .pulse_o  (div_pulse)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= CTRL_RST;
    else if (rst_fire)  ctrl_q <= CTRL_RST;
    else if (ctrl_wr_i) ctrl_q <= ctrl_wdata;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asleep_q <= 1'b0;
      pd_o     <= 1'b1;
      to_o     <= 1'b1;
    end else begin
      if (sleep_i)  asleep_q <= 1'b1;
      else if (tmo) asleep_q <= 1'b0;
      if (sleep_i) begin
        pd_o <= 1'b0;
        to_o <= 1'b1;
      end else if (clrwdt_i) begin
        pd_o <= 1'b1;
        to_o <= 1'b1;
      end else if (tmo) begin
        to_o <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdt_rst_o <= 1'b0;
      wake_o    <= 1'b0;
      tmr_inc_o <= 1'b0;
    end else begin
      wdt_rst_o <= rst_fire;
      wake_o    <= tmo & asleep_q;
      tmr_inc_o <= psa ? tmr_clk_i : div_pulse;
    end
  end

  // R12
  no_dual_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wdt_rst_o && wake_o));
  // R6
  tmo_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_rst_o || wake_o) |-> $past(wdt_en_i));
  // R8
  sleep_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (!pd_o && to_o));
  // R7
  clr_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clrwdt_i && !sleep_i) |=> (pd_o && to_o));
  // R9
  rst_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);
  // R9
  rst_clears_to_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> !to_o);
  // R10
  wake_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
endmodule

// File: tb/sim_wdt_shared_div.sv
`timescale 1ns/1ps
module sim_wdt_shared_div;
  localparam int BASE_W = 3;
  localparam int BASE_P = 1 << BASE_W;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wdt_tick_i = 0, tmr_clk_i = 0, wdt_en_i = 1, ctrl_wr_i = 0;
  logic [3:0] ctrl_d_i = '0;
  logic clrwdt_i = 0, sleep_i = 0;
  logic wdt_rst_o, wake_o, tmr_inc_o, pd_o, to_o;

  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  wdt_shared_div #(.BASE_W(BASE_W), .DIV_W(8)) u0 (.*);

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic m);
    wdt_tick_i = t; tmr_clk_i = m;
    @(posedge clk_i); #1;
    wdt_tick_i = 0; tmr_clk_i = 0;
  endtask

  task automatic do_ctrl(input logic [3:0] d);
    ctrl_wr_i = 1; ctrl_d_i = d;
    @(posedge clk_i); #1;
    ctrl_wr_i = 0;
  endtask

  task automatic do_clr();
    clrwdt_i = 1; @(posedge clk_i); #1; clrwdt_i = 0;
  endtask

  task automatic do_sleep();
    sleep_i = 1; @(posedge clk_i); #1; sleep_i = 0;
  endtask

  task automatic run_ticks(input int lim, output int n, output logic was_wake);
    n = 0; was_wake = 0;
    for (int i = 1; i <= lim; i++) begin
      step(1, 0);
      if (wdt_rst_o || wake_o) begin
        n = i; was_wake = wake_o;
        return;
      end
    end
  endtask

  task automatic run_tmr(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      step(0, 1);
      if (tmr_inc_o) begin n = i; return; end
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int n; logic w;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    // R1 reset state
    chk(pd_o, 1, "R1 pd"); chk(to_o, 1, "R1 to");
    chk(wdt_rst_o, 0, "R1 rst"); chk(wake_o, 0, "R1 wake"); chk(tmr_inc_o, 0, "R1 inc");
    run_ticks(3000, n, w);
    chk(n, BASE_P * 128, "R1 default ratio");
    chk(to_o, 0, "R9 to cleared");
    chk(pd_o, 1, "R9 pd kept");

    // R2 R3 watchdog postscale sweep
    for (int r = 0; r < 8; r++) begin
      do_ctrl(4'(8 + r)); do_clr();
      run_ticks(3000, n, w);
      chk(n, BASE_P << r, "R3 postscale period");
      chk(w, 0, "R9 rst not wake");
    end

    // R9 control returns to all ones after an awake timeout
    do_ctrl(4'd8); do_clr();
    run_ticks(100, n, w);
    chk(n, BASE_P, "R9 ratio 0 first");
    run_ticks(3000, n, w);
    chk(n, BASE_P * 128, "R9 ctrl reset");

    // R4 watchdog direct when timer owns divider
    do_ctrl(4'd2); do_clr();
    run_ticks(100, n, w);
    chk(n, BASE_P, "R4 direct timeout");

    // R4 timer prescale sweep
    for (int r = 0; r < 8; r++) begin
      do_ctrl(4'(8 + r)); do_ctrl(4'(r));
      run_tmr(600, n);
      chk(n, 2 << r, "R4 prescale first");
      run_tmr(600, n);
      chk(n, 2 << r, "R4 prescale repeat");
    end

    // R5 pass-through
    do_ctrl(4'd11);
    step(0, 1); chk(tmr_inc_o, 1, "R5 pass");
    step(0, 0); chk(tmr_inc_o, 0, "R5 idle");

    // R11 select change clears divider
    do_ctrl(4'd10); do_ctrl(4'd2);
    run_tmr(5, n); chk(n, 0, "R11 partial");
    do_ctrl(4'd10); do_ctrl(4'd2);
    run_tmr(100, n); chk(n, 8, "R11 cleared");

    // R6 enable low holds count
    do_ctrl(4'd0); do_clr();
    for (int i = 0; i < 5; i++) step(1, 0);
    wdt_en_i = 0;
    run_ticks(100, n, w); chk(n, 0, "R6 no timeout");
    wdt_en_i = 1;
    run_ticks(100, n, w); chk(n, BASE_P - 5, "R6 held count");

    // R7 clear restarts count
    do_ctrl(4'd9); do_clr();
    for (int i = 0; i < 10; i++) step(1, 0);
    do_clr();
    chk(pd_o, 1, "R7 pd"); chk(to_o, 1, "R7 to");
    run_ticks(100, n, w); chk(n, 2 * BASE_P, "R7 restart");

    // R8 R10 sleep then wake
    do_ctrl(4'd9); do_clr();
    for (int i = 0; i < 5; i++) step(1, 0);
    do_sleep();
    chk(pd_o, 0, "R8 pd"); chk(to_o, 1, "R8 to");
    run_ticks(100, n, w);
    chk(n, 2 * BASE_P, "R8 restart in sleep");
    chk(w, 1, "R10 wake");
    chk(wdt_rst_o, 0, "R12 no rst on wake");
    chk(to_o, 0, "R10 to cleared");
    step(0, 0); chk(wake_o, 0, "R10 one cycle");
    run_ticks(100, n, w);
    chk(n, 2 * BASE_P, "R10 ctrl kept");
    chk(w, 0, "R9 awake rst");

    summary();
    $finish;
  end
endmodule